// File: doc/BRIEF.md
# Two-Phase Ternary Search Engine

This block runs one search command that reaches it over two consecutive clock cycles on a 9-bit command bus, with a valid strobe and a 68-bit data bus. The first cycle (phase A) names the global mask register and two upper address bits. The second cycle (phase B) names a comparand register and a result register. The 68-bit key seen in phase A, gated by the selected mask, is compared against a small table of ternary entries that the surrounding logic presents. Each entry has data, a per-bit care mask and a valid bit. The lowest-numbered matching entry wins.

The engine keeps sixteen 136-bit comparand registers and eight result registers. A search writes the word from both phases into the named comparand register. It writes the hit flag and the address into the named result register. It also drives a one-cycle result strobe with a hit flag and the result address. A new search may start in the cycle right after phase B, so searches can run back to back on consecutive phase pairs. Storage for the table and the mask registers lives outside the block.

Top module: `dual_phase_search`

## Requirements
- R1: Phase A is accepted when `cmd_vld` is 1, `cmd[1:0]` is 2'b10 and `cmd[2]` is 0, while the engine waits for phase A. The very next cycle is phase B, and the search is launched only if `cmd_vld` is 1 and `cmd[1:0]` is 2'b10 in that cycle.
- R2: When a search launches, comparand register `cmd[5:2]` (phase B value) is loaded. Bits 135:68 get the phase A `dq` and bits 67:0 get the phase B `dq`.
- R3: Entry i matches when `tbl_valid[i]` is 1 and the phase A `dq` equals `tbl_data[i]` on every bit where both `tbl_care[i]` and `gmr_even[cmd[5:3]]` (phase A value) are 1. The phase B `dq` takes no part in the compare.
- R4: When several entries match, the lowest index wins. On a hit, `res_addr[21:20]` equals phase A `cmd[8:7]` and `res_addr[19:0]` is the winning index, zero-extended.
- R5: If phase B is sampled at clock edge t, `res_vld` is 1 for exactly the cycle that follows edge t+1, and `res_hit` is 1 in that cycle only if some entry matched.
- R6: On a miss, `res_addr` is 0. Whenever `res_vld` is 0, both `res_hit` and `res_addr` are 0.
- R7: At the same edge that sets the result outputs, result register `cmd[8:6]` (phase B value) is loaded with bit 22 = hit flag and bits 21:0 = result address. A miss therefore stores all zeros.
- R8: The command is discarded in three cases: phase A has `cmd[2]` = 1, phase B has an opcode other than 2'b10, or phase B has `cmd_vld` = 0. A discarded command changes no comparand or result register and raises no `res_vld`.
- R9: Searches on consecutive A/B cycle pairs each produce their own result, with no idle cycle between them.
- R10: A synchronous reset clears all comparand registers, all result registers, the result outputs and the phase tracker, so that the engine waits for phase A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_vld | input | 1 | Command valid strobe |
| cmd | input | 9 | Command bus; field meaning depends on phase |
| dq | input | 68 | Compare/comparand data |
| gmr_even | input | 8x68 | Even register of each global mask pair |
| tbl_data | input | ENTRIESx68 | Table entry data |
| tbl_care | input | ENTRIESx68 | Per-entry care mask (1 = bit compared) |
| tbl_valid | input | ENTRIES | Per-entry valid bit |
| res_vld | output | 1 | Result strobe, one cycle |
| res_hit | output | 1 | Hit flag, meaningful with res_vld |
| res_addr | output | 22 | Result address |
| cmp_q | output | 16x136 | Comparand register contents |
| rslt_q | output | 8x23 | Result register contents {hit, addr} |

## Verification
Phase A and phase B are driven on successive falling edges. A search's result strobe, hit flag and address are read at the falling edge after the second rising edge past phase B. The bench also checks that they are still low one cycle earlier. The comparand register is updated at the phase B edge and the result register one edge later, so both are read at that same falling edge. For back-to-back searches, the first result is read in the cycle where the second phase B is being driven, before those inputs change. For discarded commands, the strobe is watched for two cycles and every register is compared against the bench's mirror.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int DATA_W  = 68;
  localparam int CMD_W   = 9;
  localparam int ADDR_W  = 22;
  localparam int HI_W    = 2;
  localparam int LOW_W   = ADDR_W - HI_W;
  localparam int GMR_IW  = 3;
  localparam int CMP_IW  = 4;
  localparam int RES_IW  = 3;
  localparam int NGMR    = 1 << GMR_IW;
  localparam int NCMP    = 1 << CMP_IW;
  localparam int NRES    = 1 << RES_IW;
  localparam int CWORD_W = 2 * DATA_W;
  localparam int RREG_W  = ADDR_W + 1;

  localparam logic [1:0] OP_SEARCH = 2'b10;

  typedef enum logic {PH_WAIT_A = 1'b0, PH_WAIT_B = 1'b1} phase_e;

  typedef struct packed {
    logic [GMR_IW-1:0] gmr_idx;
    logic [HI_W-1:0]   hi;
    logic [CMP_IW-1:0] cmp_idx;
    logic [RES_IW-1:0] res_idx;
    logic [DATA_W-1:0] key;
  } srch_req_t;

  // ternary compare of one entry: only bits cared by both masks count
  function automatic logic entry_match(input logic [DATA_W-1:0] key,
                                       input logic [DATA_W-1:0] ent,
                                       input logic [DATA_W-1:0] care,
                                       input logic [DATA_W-1:0] gmask,
                                       input logic              vld);
    return vld && (((key ^ ent) & care & gmask) == '0);
  endfunction

  function automatic logic [ADDR_W-1:0] make_addr(input logic [HI_W-1:0]  hi,
                                                  input logic [LOW_W-1:0] low);
    return {hi, low};
  endfunction
endpackage

// File: rtl/dps_phase_ctl.sv
module dps_phase_ctl
  import dps_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_vld,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [DATA_W-1:0] dq,
  output logic              take_a,
  output logic              take_b,
  output logic              drop_b,
  output srch_req_t         req,
  output logic [CWORD_W-1:0] cword
);
  phase_e ph_q;
  logic   op_ok;
  logic [GMR_IW-1:0] gmr_q;
  logic [HI_W-1:0]   hi_q;
  logic [DATA_W-1:0] key_q;

  assign op_ok  = cmd_vld && (cmd[1:0] == OP_SEARCH);
  assign take_a = (ph_q == PH_WAIT_A) && op_ok && !cmd[2];
  assign take_b = (ph_q == PH_WAIT_B) && op_ok;
  assign drop_b = (ph_q == PH_WAIT_B) && !op_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= PH_WAIT_A;
    end else if (ph_q == PH_WAIT_B) begin
      ph_q <= PH_WAIT_A;
    end else if (take_a) begin
      ph_q <= PH_WAIT_B;
    end
  end

  always_ff @(posedge clk) begin
    if (take_a) begin
      gmr_q <= cmd[5:3];
      hi_q  <= cmd[8:7];
      key_q <= dq;
    end
  end

  always_comb begin
    req.gmr_idx = gmr_q;
    req.hi      = hi_q;
    req.cmp_idx = cmd[5:2];
    req.res_idx = cmd[8:6];
    req.key     = key_q;
  end

  assign cword = {key_q, dq};
endmodule

// File: rtl/dps_cmp_bank.sv
module dps_cmp_bank
  import dps_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [CMP_IW-1:0]            wr_sel,
  input  logic [CWORD_W-1:0]           wr_word,
  output logic [NCMP-1:0][CWORD_W-1:0] regs_q
);
  for (genvar g = 0; g < NCMP; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[g] <= '0;
      end else if (wr_en && (wr_sel == CMP_IW'(g))) begin
        regs_q[g] <= wr_word;
      end
    end
  end
endmodule

// File: rtl/dps_match.sv
module dps_match
  import dps_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
)(
  input  logic [DATA_W-1:0]              key,
  input  logic [DATA_W-1:0]              gmask,
  input  logic [ENTRIES-1:0][DATA_W-1:0] tbl_data,
  input  logic [ENTRIES-1:0][DATA_W-1:0] tbl_care,
  input  logic [ENTRIES-1:0]             tbl_valid,
  output logic                           any_hit,
  output logic [IDX_W-1:0]               win_idx
);
  logic [ENTRIES-1:0] hit_vec;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign hit_vec[e] = entry_match(key, tbl_data[e], tbl_care[e], gmask, tbl_valid[e]);
  end

  assign any_hit = |hit_vec;

  // lowest index wins: scan from the top so the last assignment is the lowest
  always_comb begin
    win_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) win_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dps_rslt_bank.sv
module dps_rslt_bank
  import dps_pkg::*;
#(
  parameter int IDX_W = 3
)(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        s1_vld,
  input  logic                        s1_hit,
  input  logic [IDX_W-1:0]            s1_idx,
  input  logic [HI_W-1:0]             s1_hi,
  input  logic [RES_IW-1:0]           s1_sel,
  output logic                        res_vld,
  output logic                        res_hit,
  output logic [ADDR_W-1:0]           res_addr,
  output logic [NRES-1:0][RREG_W-1:0] regs_q
);
  logic [ADDR_W-1:0] hit_addr;

  assign hit_addr = s1_hit ? make_addr(s1_hi, LOW_W'(s1_idx)) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld  <= 1'b0;
      res_hit  <= 1'b0;
      res_addr <= '0;
    end else begin
      res_vld  <= s1_vld;
      res_hit  <= s1_vld && s1_hit;
      res_addr <= s1_vld ? hit_addr : '0;
    end
  end

  for (genvar g = 0; g < NRES; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[g] <= '0;
      end else if (s1_vld && (s1_sel == RES_IW'(g))) begin
        regs_q[g] <= {s1_hit, hit_addr};
      end
    end
  end
endmodule

// File: rtl/dual_phase_search.sv
module dual_phase_search
  import dps_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
)(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cmd_vld,
  input  logic [CMD_W-1:0]             cmd,
  input  logic [DATA_W-1:0]            dq,
  input  logic [NGMR-1:0][DATA_W-1:0]  gmr_even,
  input  logic [ENTRIES-1:0][DATA_W-1:0] tbl_data,
  input  logic [ENTRIES-1:0][DATA_W-1:0] tbl_care,
  input  logic [ENTRIES-1:0]           tbl_valid,
  output logic                         res_vld,
  output logic                         res_hit,
  output logic [ADDR_W-1:0]            res_addr,
  output logic [NCMP-1:0][CWORD_W-1:0] cmp_q,
  output logic [NRES-1:0][RREG_W-1:0]  rslt_q
);
  // named internal events, used by the bound checker
  logic         take_a;
  logic         take_b;
  logic         drop_b;
  srch_req_t    req;
  logic [CWORD_W-1:0] cword;

  logic         s1_vld;
  srch_req_t    s1_req;
  logic         m_hit;
  logic [IDX_W-1:0] m_idx;

  dps_phase_ctl u_phase (
    .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd(cmd), .dq(dq),
    .take_a(take_a), .take_b(take_b), .drop_b(drop_b),
    .req(req), .cword(cword)
  );

  dps_cmp_bank u_cmp (
    .clk(clk), .rst(rst), .wr_en(take_b), .wr_sel(req.cmp_idx),
    .wr_word(cword), .regs_q(cmp_q)
  );

  // compare stage register: cuts the path from command pins to the table compare
  always_ff @(posedge clk) begin
    if (rst) s1_vld <= 1'b0;
    else     s1_vld <= take_b;
  end

  always_ff @(posedge clk) begin
    if (take_b) s1_req <= req;
  end

  dps_match #(.ENTRIES(ENTRIES)) u_match (
    .key(s1_req.key), .gmask(gmr_even[s1_req.gmr_idx]),
    .tbl_data(tbl_data), .tbl_care(tbl_care), .tbl_valid(tbl_valid),
    .any_hit(m_hit), .win_idx(m_idx)
  );

  dps_rslt_bank #(.IDX_W(IDX_W)) u_rslt (
    .clk(clk), .rst(rst), .s1_vld(s1_vld), .s1_hit(m_hit), .s1_idx(m_idx),
    .s1_hi(s1_req.hi), .s1_sel(s1_req.res_idx),
    .res_vld(res_vld), .res_hit(res_hit), .res_addr(res_addr), .regs_q(rslt_q)
  );
endmodule

// File: rtl/dps_chk.sv
module dps_chk
  import dps_pkg::*;
#(
  parameter int ENTRIES = 8
)(
  input logic              clk,
  input logic              rst,
  input logic              take_a,
  input logic              take_b,
  input logic              drop_b,
  input logic              res_vld,
  input logic              res_hit,
  input logic [ADDR_W-1:0] res_addr
);
  AST_B_AFTER_A: assert property (@(posedge clk) disable iff (rst)
    take_b |-> $past(take_a)) else $error("phase B launched without phase A"); // R1

  AST_RESULT_DUE: assert property (@(posedge clk) disable iff (rst)
    take_b |-> ##2 res_vld) else $error("result strobe late or missing"); // R5

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_vld |=> !res_vld) else $error("result strobe longer than one cycle"); // R5

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (rst)
    drop_b |-> ##2 !res_vld) else $error("discarded command produced a result"); // R8

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (res_vld && !res_hit) |-> (res_addr == '0)) else $error("miss with nonzero address"); // R6

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !res_vld |-> (!res_hit && res_addr == '0)) else $error("outputs active without strobe"); // R6

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> (res_addr[LOW_W-1:0] < LOW_W'(ENTRIES))) else $error("hit index out of table"); // R4
endmodule

bind dual_phase_search dps_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst(rst), .take_a(take_a), .take_b(take_b), .drop_b(drop_b),
  .res_vld(res_vld), .res_hit(res_hit), .res_addr(res_addr)
);

// File: tb/dual_phase_search_tb.sv
module dual_phase_search_tb;
  import dps_pkg::*;
  localparam int ENT = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, cmd_vld;
  logic [CMD_W-1:0]  cmd;
  logic [DATA_W-1:0] dq;
  logic [NGMR-1:0][DATA_W-1:0] gmr;
  logic [ENT-1:0][DATA_W-1:0]  tdat, tcare;
  logic [ENT-1:0]              tvld;
  logic res_vld, res_hit;
  logic [ADDR_W-1:0] res_addr;
  logic [NCMP-1:0][CWORD_W-1:0] cmp_q;
  logic [NRES-1:0][RREG_W-1:0]  rslt_q;

  logic [NCMP-1:0][CWORD_W-1:0] m_cmp;
  logic [NRES-1:0][RREG_W-1:0]  m_res;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  dual_phase_search #(.ENTRIES(ENT)) u_dut (
    .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd(cmd), .dq(dq),
    .gmr_even(gmr), .tbl_data(tdat), .tbl_care(tcare), .tbl_valid(tvld),
    .res_vld(res_vld), .res_hit(res_hit), .res_addr(res_addr),
    .cmp_q(cmp_q), .rslt_q(rslt_q)
  );

  task automatic check(input bit ok, input string req, input logic [135:0] act, input logic [135:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] rnd68();
    logic [95:0] t;
    t = {$urandom(), $urandom(), $urandom()};
    return t[DATA_W-1:0];
  endfunction

  // bench model: bit-by-bit ternary scan, first valid matching entry wins
  function automatic void model(input logic [DATA_W-1:0] key, input logic [DATA_W-1:0] mask,
                                output bit hit, output logic [ADDR_W-1:0] low);
    hit = 0; low = '0;
    for (int i = 0; i < ENT; i++) begin
      bit ok = tvld[i];
      for (int b = 0; b < DATA_W; b++)
        if (tcare[i][b] && mask[b] && (key[b] != tdat[i][b])) ok = 0;
      if (ok && !hit) begin hit = 1; low = ADDR_W'(i); end
    end
  endfunction

  function automatic logic [ADDR_W-1:0] exp_addr(input bit hit, input logic [1:0] hi, input logic [ADDR_W-1:0] low);
    if (!hit) return '0;
    return (ADDR_W'(hi) << LOW_W) + low;
  endfunction

  function automatic logic [CMD_W-1:0] cmd_a(input logic [2:0] g, input logic [1:0] hi);
    return {hi, 1'($urandom()), g, 1'b0, 2'b10};
  endfunction

  function automatic logic [CMD_W-1:0] cmd_b(input logic [2:0] s, input logic [3:0] c);
    return {s, c, 2'b10};
  endfunction

  task automatic drive(input bit v, input logic [CMD_W-1:0] c, input logic [DATA_W-1:0] d);
    @(negedge clk);
    cmd_vld = v; cmd = c; dq = d;
  endtask

  task automatic rand_table();
    for (int i = 0; i < ENT; i++) begin
      tdat[i]  = rnd68();
      tcare[i] = rnd68() | rnd68();
      tvld[i]  = ($urandom() % 5) != 0;
    end
  endtask

  function automatic logic [DATA_W-1:0] pick_key(input logic [2:0] g);
    int j = $urandom() % ENT;
    if (($urandom() % 4) == 0) return rnd68();
    return tdat[j] ^ (rnd68() & ~(tcare[j] & gmr[g]));
  endfunction

  task automatic check_result(input bit h, input logic [ADDR_W-1:0] ea, input logic [2:0] s, input string tag);
    check(res_vld == 1'b1, {"R5 strobe ", tag}, 136'(res_vld), 136'(1));
    check(res_hit == h, {"R3 hit ", tag}, 136'(res_hit), 136'(h));
    check(res_addr == ea, h ? {"R4 addr ", tag} : {"R6 miss addr ", tag}, 136'(res_addr), 136'(ea));
    m_res[s] = {h, ea};
    check(rslt_q == m_res, {"R7 result reg ", tag}, 136'(rslt_q[s]), 136'(m_res[s]));
  endtask

  task automatic search(input logic [2:0] g, input logic [1:0] hi, input logic [3:0] c,
                        input logic [2:0] s, input logic [DATA_W-1:0] key, input string tag);
    bit h; logic [ADDR_W-1:0] low, ea; logic [DATA_W-1:0] bd;
    bd = rnd68();
    model(key, gmr[g], h, low);
    ea = exp_addr(h, hi, low);
    drive(1, cmd_a(g, hi), key);
    drive(1, cmd_b(s, c), bd);
    drive(0, '0, '0);
    check(res_vld == 1'b0, {"R5 not early ", tag}, 136'(res_vld), 136'(0));
    @(negedge clk);
    check_result(h, ea, s, tag);
    m_cmp[c] = {key, bd};
    check(cmp_q == m_cmp, {"R2 comparand ", tag}, cmp_q[c], m_cmp[c]);
  endtask

  // R9: two searches on consecutive A/B pairs
  task automatic pair_search();
    logic [2:0] g1 = 3'($urandom()), g2 = 3'($urandom()), s1 = 3'($urandom()), s2 = 3'($urandom());
    logic [3:0] c1 = 4'($urandom()), c2 = 4'($urandom());
    logic [1:0] h1 = 2'($urandom()), h2 = 2'($urandom());
    logic [DATA_W-1:0] k1 = pick_key(g1), k2 = pick_key(g2), b1 = rnd68(), b2 = rnd68();
    bit x1, x2; logic [ADDR_W-1:0] l1, l2;
    model(k1, gmr[g1], x1, l1);
    model(k2, gmr[g2], x2, l2);
    drive(1, cmd_a(g1, h1), k1);
    drive(1, cmd_b(s1, c1), b1);
    drive(1, cmd_a(g2, h2), k2);
    @(negedge clk);
    check_result(x1, exp_addr(x1, h1, l1), s1, "R9 first");
    cmd_vld = 1; cmd = cmd_b(s2, c2); dq = b2;
    drive(0, '0, '0);
    check(res_vld == 1'b0, "R9 gap", 136'(res_vld), 136'(0));
    @(negedge clk);
    check_result(x2, exp_addr(x2, h2, l2), s2, "R9 second");
    m_cmp[c1] = {k1, b1};
    m_cmp[c2] = {k2, b2};
    check(cmp_q == m_cmp, "R9 comparands", cmp_q[c2], m_cmp[c2]);
  endtask

  // R8: kind 0 = cmd[2] set in A, 1 = wrong opcode in B, 2 = strobe low in B
  task automatic discard(input int kind);
    logic [CMD_W-1:0] a = cmd_a(3'($urandom()), 2'($urandom()));
    logic [CMD_W-1:0] b = cmd_b(3'($urandom()), 4'($urandom()));
    if (kind == 0) begin a[2] = 1'b1; b[2] = 1'b1; end
    if (kind == 1) b[1:0] = 2'b01;
    drive(1, a, rnd68());
    drive(kind != 2, b, rnd68());
    drive(0, '0, '0);
    check(res_vld == 1'b0, "R8 no result +1", 136'(res_vld), 136'(0));
    @(negedge clk);
    check(res_vld == 1'b0, "R8 no result +2", 136'(res_vld), 136'(0));
    check(cmp_q == m_cmp, "R8 comparands kept", 136'(kind), 136'(kind));
    check(rslt_q == m_res, "R8 result regs kept", 136'(kind), 136'(kind));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; cmd_vld = 0; cmd = '0; dq = '0;
    m_cmp = '0; m_res = '0;
    for (int g = 0; g < NGMR; g++) gmr[g] = rnd68();
    gmr[0] = '1;
    gmr[7] = '0;
    rand_table();
    repeat (3) @(negedge clk);
    rst = 0;
    check(res_vld == 0 && res_hit == 0 && res_addr == 0, "R10 reset outputs", 136'(res_addr), 136'(0));
    check(cmp_q == '0, "R10 reset comparands", cmp_q[0], 136'(0));
    check(rslt_q == '0, "R10 reset result regs", 136'(rslt_q[0]), 136'(0));

    // R6: every entry invalid gives a miss
    tvld = '0;
    search(3'd0, 2'b11, 4'd3, 3'd2, tdat[1], "all invalid");
    // R4: entries 2 and 5 both match exactly, entry 0 matches but invalid
    rand_table();
    tcare[2] = '1; tcare[5] = '1; tcare[0] = '1;
    tdat[5] = tdat[2]; tdat[0] = tdat[2];
    tvld = 8'b0010_0110;
    search(3'd0, 2'b10, 4'd15, 3'd7, tdat[2], "lowest wins");
    // R3: zero mask makes every valid entry match; lowest valid index is 1
    search(3'd7, 2'b01, 4'd0, 3'd0, rnd68(), "zero mask");
    // R4: only the top entry valid and matching, high bits 11
    tvld = 8'b1000_0000; tcare[7] = '1;
    search(3'd0, 2'b11, 4'd8, 3'd4, tdat[7], "top entry");
    // R3: phase B data differs from A; key one bit off under full mask -> miss
    search(3'd0, 2'b11, 4'd9, 3'd5, tdat[7] ^ 68'd1, "one bit off");

    for (int k = 0; k < 3; k++) discard(k);
    pair_search();

    rand_table();
    for (int n = 0; n < 300; n++) begin
      int r = $urandom() % 12;
      if ((n % 60) == 59) rand_table();
      if (r == 0) discard($urandom() % 3);
      else if (r < 3) pair_search();
      else begin
        logic [2:0] g = 3'($urandom());
        search(g, 2'($urandom()), 4'($urandom()), 3'($urandom()), pick_key(g), "random");
      end
    end

    // R10: reset between phase A and phase B clears the phase tracker and registers
    drive(1, cmd_a(3'd1, 2'b01), rnd68());
    @(negedge clk);
    rst = 1; cmd_vld = 0;
    @(negedge clk);
    rst = 0;
    cmd_vld = 1; cmd = cmd_b(3'd3, 4'd5);
    m_cmp = '0; m_res = '0;
    drive(0, '0, '0);
    check(res_vld == 0, "R10 no result after reset +1", 136'(res_vld), 136'(0));
    @(negedge clk);
    check(res_vld == 0, "R10 no result after reset +2", 136'(res_vld), 136'(0));
    check(cmp_q == '0, "R10 comparands cleared", cmp_q[5], 136'(0));
    check(rslt_q == '0, "R10 result regs cleared", 136'(rslt_q[3]), 136'(0));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule